// File: doc/BRIEF.md
# Delayed LMS Weight-Increment Unit

This block keeps four adaptive FIR coefficients and advances them once per sample clock with a delayed least-mean-square rule. Each clock it takes the error word (desired sample minus filter output) and the four input samples that belong to its taps. It carries both through a two-stage register delay line, so every update uses the error and inputs from two sample periods earlier. The step size is fixed at 1/16. It is applied by dropping the four least significant error bits, so no multiplier is spent on it.

The truncated error is split into a sign and a magnitude. The magnitude is multiplied by each tap's delayed input and rescaled to the weight format. The sign is applied to that product, and the signed increment is added to the stored weight with saturation. The filtering datapath and the partial-sum table are separate blocks. They read the weights from `w_out`.

A small controller has two states. ST_PRIME is entered on every reset. In it the weights are held while the delay line fills, and the controller stays there through transition T_FILL. Once DELAY edges have passed, transition T_ARM moves it to ST_RUN. ST_RUN loops on itself through T_HOLD and updates the weights on every edge. Transition T_CLEAR returns the controller to ST_PRIME from either state whenever reset is high.

Top module: `dlms_wiu`

## Requirements
- R1: While `rst` is high at a clock edge, all weights and both delay stages become zero. `w_out` reads zero after that edge.
- R2: For the first two clock edges after reset is released, the weights stay unchanged whatever the inputs are.
- R3: An error and input vector presented at clock edge t first change the weights visible after edge t+2, and no earlier.
- R4: The error is 20-bit two's complement. Its 4 LSBs are dropped (floor, arithmetic shift right by 4). Error values 0..15 give no weight change, and 16 acts as a scaled error of 1.
- R5: The scaled error is separated into sign and magnitude. The increment is the sign applied to floor(magnitude × x / 2^15). For example, error −16 with x = 32767 leaves a weight unchanged, and error −16 with x = −32768 adds +1.
- R6: Weights and input samples are 16-bit two's complement, Q1.15. Tap k occupies bits [16k+15:16k] of `x_in` and `w_out`. Each weight in ST_RUN becomes the saturated value of old weight plus its increment.
- R7: A sum above 32767 is clamped to 32767, and it does not wrap.
- R8: A sum below −32768 is clamped to −32768, and it does not wrap.
- R9: Each tap's increment depends only on the shared error and that tap's own input sample. A zero input on a tap leaves that tap unchanged.
- R10: A weight moves only in the direction of (error sign XOR input sign), or not at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| err_in | input | 20 | Error word, two's complement |
| x_in | input | 64 | Four input samples, tap k at bits [16k+15:16k] |
| w_out | output | 64 | Four current weights, tap k at bits [16k+15:16k] |

## Verification
Saturation and the negative branch of the sign-magnitude separator can act on the same tap in the same cycle. The bench provokes this by driving full-scale errors against −32768 inputs until a weight pins at −32768. A bench model with integer arithmetic computes the clamp after the sign is applied, and the bench compares against it. Reset can also arrive while both delay stages hold nonzero words. The bench raises reset mid-run and checks that the weights are zero and stay zero through the two priming edges, even though the inputs are large.

// File: rtl/dlms_pkg.sv
package dlms_pkg;

    typedef enum logic [0:0] {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } dlms_state_e;

endpackage

// File: rtl/dlms_delay.sv
module dlms_delay #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/dlms_sm_sep.sv
module dlms_sm_sep #(
    parameter int W_L   = 16,
    parameter int LOG2N = 4,
    localparam int ERR_W = W_L + LOG2N
) (
    input  logic [ERR_W-1:0] err,
    output logic             sign,
    output logic [W_L-1:0]   mag
);
    logic [W_L-1:0]   e_trunc;
    logic [LOG2N-1:0] drop_unused;

    // step size 1/2^LOG2N: keep the upper word, discard the low bits
    assign {e_trunc, drop_unused} = err;
    assign sign = e_trunc[W_L-1];
    assign mag  = sign ? (~e_trunc + 1'b1) : e_trunc;
endmodule

// File: rtl/dlms_tap_upd.sv
module dlms_tap_upd #(
    parameter int W_L = 16
) (
    input  logic           sign,
    input  logic [W_L-1:0] mag,
    input  logic [W_L-1:0] x,
    input  logic [W_L-1:0] w_cur,
    output logic [W_L-1:0] w_nxt
);
    localparam int PW = 2 * W_L + 1;
    localparam int SW = W_L + 2;
    localparam logic signed [SW-1:0] MAXV = {3'b000, {(W_L-1){1'b1}}};
    localparam logic signed [SW-1:0] MINV = {3'b111, {(W_L-1){1'b0}}};

    logic signed [PW-1:0]  prod;
    logic signed [SW-1:0]  inc_abs;
    logic        [W_L-2:0] prod_unused_lo;
    logic signed [SW-1:0]  inc;
    logic signed [SW-1:0]  sum;

    assign prod = $signed({1'b0, mag}) * $signed(x);
    // floor division by 2^(W_L-1): upper bits of the product
    assign {inc_abs, prod_unused_lo} = prod;
    assign inc = sign ? -inc_abs : inc_abs;
    assign sum = $signed({{2{w_cur[W_L-1]}}, w_cur}) + inc;

    always_comb begin
        if (sum > MAXV)      w_nxt = MAXV[W_L-1:0];
        else if (sum < MINV) w_nxt = MINV[W_L-1:0];
        else                 w_nxt = sum[W_L-1:0];
    end
endmodule

// File: rtl/dlms_wiu.sv
module dlms_wiu
    import dlms_pkg::*;
#(
    parameter int W_L   = 16,
    parameter int TAPS  = 4,
    parameter int LOG2N = 4,
    parameter int DELAY = 2,
    localparam int ERR_W = W_L + LOG2N,
    localparam int VEC_W = TAPS * W_L
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ERR_W-1:0] err_in,
    input  logic [VEC_W-1:0] x_in,
    output logic [VEC_W-1:0] w_out
);
    localparam int FILL_W = $clog2(DELAY + 1);

    dlms_state_e      state_q, state_d;
    logic [FILL_W-1:0] fill_q, fill_d;
    logic              run;
    logic [ERR_W-1:0]  err_d;
    logic [VEC_W-1:0]  x_d;
    logic              e_sign;
    logic [W_L-1:0]    e_mag;
    logic [VEC_W-1:0]  w_q;
    logic [VEC_W-1:0]  w_nxt;

    dlms_delay #(.W(ERR_W), .DEPTH(DELAY)) u_err_dly (
        .clk(clk), .rst(rst), .d(err_in), .q(err_d)
    );

    dlms_delay #(.W(VEC_W), .DEPTH(DELAY)) u_x_dly (
        .clk(clk), .rst(rst), .d(x_in), .q(x_d)
    );

    dlms_sm_sep #(.W_L(W_L), .LOG2N(LOG2N)) u_sep (
        .err(err_d), .sign(e_sign), .mag(e_mag)
    );

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        dlms_tap_upd #(.W_L(W_L)) u_upd (
            .sign (e_sign),
            .mag  (e_mag),
            .x    (x_d[k*W_L +: W_L]),
            .w_cur(w_q[k*W_L +: W_L]),
            .w_nxt(w_nxt[k*W_L +: W_L])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PRIME;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
        end
    end

    // transitions: T_FILL, T_ARM, T_HOLD
    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        unique case (state_q)
            ST_PRIME: begin
                if (fill_q == FILL_W'(DELAY - 1)) begin
                    state_d = ST_RUN;
                    fill_d  = '0;
                end else begin
                    fill_d = fill_q + 1'b1;
                end
            end
            ST_RUN: state_d = ST_RUN;
            default: begin
                state_d = ST_PRIME;
                fill_d  = '0;
            end
        endcase
    end

    assign run = (state_q == ST_RUN);

    // output (weight) register
    always_ff @(posedge clk) begin
        if (rst)      w_q <= '0;
        else if (run) w_q <= w_nxt;
    end

    assign w_out = w_q;
endmodule

// File: rtl/dlms_wiu_chk.sv
module dlms_wiu_chk #(
    parameter int W_L   = 16,
    parameter int TAPS  = 4,
    parameter int LOG2N = 4,
    parameter int DELAY = 2,
    localparam int ERR_W = W_L + LOG2N,
    localparam int VEC_W = TAPS * W_L
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic [ERR_W-1:0] err_in,
    input logic [ERR_W-1:0] err_d,
    input logic [VEC_W-1:0] x_d,
    input logic             e_sign,
    input logic [W_L-1:0]   e_mag,
    input logic [VEC_W-1:0] w_out
);
    logic       rst_d;
    logic [1:0] cnt;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst)            cnt <= '0;
        else if (cnt != 2'd3) cnt <= cnt + 1'b1;
    end

    // R1
    always @(posedge clk) begin
        if (rst_d === 1'b1) begin
            a_r1_reset_clear: assert (w_out == '0)
                else $error("a_r1_reset_clear");
        end
    end

    // R2
    a_r2_prime_hold: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(w_out));

    // R3
    if (DELAY == 2) begin : g_dly
        a_r3_two_stage: assert property (@(posedge clk) disable iff (rst)
            (cnt >= 2'd2) |-> (err_d == $past(err_in, 2)));
    end

    // R4
    a_r4_zero_mag_hold: assert property (@(posedge clk) disable iff (rst)
        (run && e_mag == '0) |=> $stable(w_out));

    // R10
    for (genvar k = 0; k < TAPS; k++) begin : g_dir
        a_r10_up_only: assert property (@(posedge clk) disable iff (rst)
            (run && !(e_sign ^ x_d[k*W_L + W_L - 1]))
            |=> ($signed(w_out[k*W_L +: W_L]) >= $signed($past(w_out[k*W_L +: W_L]))));
        a_r10_down_only: assert property (@(posedge clk) disable iff (rst)
            (run && (e_sign ^ x_d[k*W_L + W_L - 1]))
            |=> ($signed(w_out[k*W_L +: W_L]) <= $signed($past(w_out[k*W_L +: W_L]))));
    end
endmodule

bind dlms_wiu dlms_wiu_chk #(
    .W_L(W_L), .TAPS(TAPS), .LOG2N(LOG2N), .DELAY(DELAY)
) u_chk (
    .clk(clk), .rst(rst), .run(run), .err_in(err_in), .err_d(err_d),
    .x_d(x_d), .e_sign(e_sign), .e_mag(e_mag), .w_out(w_out)
);

// File: tb/dlms_wiu_test.sv
module dlms_wiu_test;
    localparam int PERIOD = 10;
    localparam int L      = 16;
    localparam int TAPS   = 4;
    localparam int LOG2N  = 4;
    localparam int ERR_W  = L + LOG2N;
    localparam int VEC_W  = TAPS * L;
    localparam int MAXW   = 32767;
    localparam int MINW   = -32768;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [ERR_W-1:0] err_in = '0;
    logic [VEC_W-1:0] x_in = '0;
    logic [VEC_W-1:0] w_out;

    int checks = 0;
    int failures = 0;
    int mw [TAPS];
    logic [ERR_W-1:0] q1e, q2e;
    logic [VEC_W-1:0] q1x, q2x;

    always #(PERIOD/2) clk = ~clk;

    dlms_wiu uut (.clk(clk), .rst(rst), .err_in(err_in), .x_in(x_in), .w_out(w_out));

    function automatic int upd(int w, logic [ERR_W-1:0] e, logic [L-1:0] x);
        longint et, mag, prod, sc, s;
        bit neg;
        et = longint'($signed(e));
        et = et >>> LOG2N;
        neg = (et < 0);
        mag = neg ? -et : et;
        prod = mag * longint'($signed(x));
        sc = prod >>> (L - 1);
        if (neg) sc = -sc;
        s = longint'(w) + sc;
        if (s > MAXW) s = MAXW;
        if (s < MINW) s = MINW;
        return int'(s);
    endfunction

    function automatic logic [VEC_W-1:0] splat(int v);
        logic [VEC_W-1:0] r;
        for (int k = 0; k < TAPS; k++) r[k*L +: L] = L'(v);
        return r;
    endfunction

    task automatic model_clear();
        for (int k = 0; k < TAPS; k++) mw[k] = 0;
        q1e = '0; q2e = '0; q1x = '0; q2x = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        err_in = 20'hFFFFF;
        x_in = splat(-32768);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic step(input logic [ERR_W-1:0] e, input logic [VEC_W-1:0] x);
        err_in = e;
        x_in = x;
        @(posedge clk);
        for (int k = 0; k < TAPS; k++) mw[k] = upd(mw[k], q2e, q2x[k*L +: L]);
        q2e = q1e; q2x = q1x;
        q1e = e;   q1x = x;
        @(negedge clk);
    endtask

    task automatic chk(string tag, int k, int exp);
        int got;
        got = int'($signed(w_out[k*L +: L]));
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s tap%0d actual=%0d expected=%0d", tag, k, got, exp);
        end
    endtask

    task automatic chk_model(string tag);
        for (int k = 0; k < TAPS; k++) chk(tag, k, mw[k]);
    endtask

    initial begin
        #(PERIOD * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int r;
        logic [ERR_W-1:0] e;
        logic [VEC_W-1:0] x;
        r = $urandom(32'd4711);
        @(negedge clk);
        do_reset();
        for (int k = 0; k < TAPS; k++) chk("R1 reset", k, 0);

        // R2: large inputs, two edges, weights still zero
        step(20'h7FFFF, splat(32767));
        step(20'h7FFFF, splat(32767));
        for (int k = 0; k < TAPS; k++) chk("R2 prime", k, 0);

        // R3: impulse at edge t affects weights after t+2
        do_reset();
        step(ERR_W'(1600), splat(16384));
        for (int k = 0; k < TAPS; k++) chk("R3 t", k, 0);
        step('0, '0);
        for (int k = 0; k < TAPS; k++) chk("R3 t+1", k, 0);
        step('0, '0);
        for (int k = 0; k < TAPS; k++) chk("R3 t+2", k, 50);

        // R4: 15 is dropped, 16 acts as 1
        do_reset();
        step(ERR_W'(15), splat(-32768));
        step('0, '0); step('0, '0);
        for (int k = 0; k < TAPS; k++) chk("R4 err15", k, 0);
        step(ERR_W'(16), splat(-32768));
        step('0, '0); step('0, '0);
        for (int k = 0; k < TAPS; k++) chk("R4 err16", k, -1);

        // R5: sign applied after magnitude scaling
        do_reset();
        step(-ERR_W'(16), splat(32767));
        step('0, '0); step('0, '0);
        for (int k = 0; k < TAPS; k++) chk("R5 neg_pos", k, 0);
        step(-ERR_W'(16), splat(-32768));
        step('0, '0); step('0, '0);
        for (int k = 0; k < TAPS; k++) chk("R5 neg_neg", k, 1);

        // R7: positive clamp
        do_reset();
        repeat (6) step(20'h7FFFF, splat(32767));
        for (int k = 0; k < TAPS; k++) chk("R7 sat_hi", k, MAXW);

        // R8: negative clamp with a negative error sign
        do_reset();
        repeat (6) step(20'h80000, splat(32767));
        for (int k = 0; k < TAPS; k++) chk("R8 sat_lo", k, MINW);
        repeat (3) step(20'h7FFFF, splat(-32768));
        for (int k = 0; k < TAPS; k++) chk("R8 sat_lo_hold", k, MINW);

        // R9: only tap 2 has an input
        do_reset();
        x = '0;
        x[2*L +: L] = 16'd16384;
        step(ERR_W'(3200), x);
        step('0, '0); step('0, '0);
        for (int k = 0; k < TAPS; k++) chk("R9 isolate", k, (k == 2) ? 100 : 0);

        // R6: random stimulus against the model, with occasional extremes
        do_reset();
        for (int i = 0; i < 2500; i++) begin
            e = ERR_W'($urandom);
            for (int k = 0; k < TAPS; k++) x[k*L +: L] = L'($urandom);
            if ((i % 37) == 0) e = 20'h7FFFF;
            if ((i % 41) == 0) e = 20'h80000;
            if ((i % 53) == 0) x = splat(-32768);
            step(e, x);
            chk_model("R6 random");
        end

        // R1: reset mid-run with full delay stages
        rst = 1'b1;
        err_in = 20'h7FFFF;
        x_in = splat(32767);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        for (int k = 0; k < TAPS; k++) chk("R1 midrun", k, 0);
        step(20'h7FFFF, splat(32767));
        step(20'h7FFFF, splat(32767));
        for (int k = 0; k < TAPS; k++) chk("R2 after_midrun", k, 0);
        step('0, '0);
        chk_model("R6 after_midrun");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule